// File: doc/BRIEF.md
# DMA Descriptor Address Generator with Control-Word Writeback

This block sits between the descriptor fetch logic and the data mover of a DMA channel. When a fetched descriptor arrives (two end pointers and a packed control word), it computes the source and destination addresses of the current transfer. It counts backwards from each end pointer, using the remaining-transfer count shifted left by that side's increment code. Each time the data mover reports a finished transfer, the block decrements the remaining count. It watches for the end of the current arbitration batch. At that point it emits the updated control word, with a one-cycle valid strobe, so that the word can be stored back to memory.

A batch holds 2^E transfers, where E is the batch exponent field of the control word. A batch also ends early when the last transfer of the whole job completes. After the final transfer, the written-back word carries mode 000, which marks the descriptor as spent. The block never drives the destination side with a size that differs from the source side. The size it reports is always the source size, and the writeback word's destination size field is overwritten with the source size.

The controller has three named states. ST_IDLE waits for a descriptor. ST_ACTIVE presents addresses and accepts transfer-done strobes. ST_WRITEBACK presents the updated control word for one cycle. The transitions are:
- LOAD: ST_IDLE to ST_ACTIVE, on a descriptor load whose mode is not 000.
- BATCH_END: ST_ACTIVE to ST_WRITEBACK, on a done strobe that completes the batch or the job.
- RETIRE: ST_WRITEBACK to ST_IDLE, always.
- All other cases hold the current state.

Top module: `dma_addr_wb`

## Requirements
- R1: While `addr_valid` is high, `src_addr` equals the source end pointer minus (remaining count << source increment code), for increment codes 00, 01 and 10. The source increment code is control bits [27:26]; the remaining count is bits [13:4].
- R2: While `addr_valid` is high, `dst_addr` equals the destination end pointer minus (remaining count << destination increment code), for codes 00, 01 and 10. The destination increment code is control bits [31:30].
- R3: An increment code of 11 on a side holds that side's address at its end pointer for every transfer.
- R4: Address arithmetic wraps modulo 2^32 when the shifted count exceeds the end pointer.
- R5: Each `xfer_done` accepted in ST_ACTIVE lowers the remaining count by one, and the next transfer's addresses follow from the new count.
- R6: After 2^E accepted transfers, where E is the batch exponent in control bits [17:14], `wb_valid` is high for exactly one cycle with `addr_valid` low, and the block then returns to ST_IDLE.
- R7: A done strobe on a transfer whose remaining count is 0 ends the job. The writeback word carries mode 000 in bits [2:0], and its count field stays 0 instead of wrapping.
- R8: The writeback word's destination size field (bits [29:28]) equals the source size (bits [25:24]). `xfer_size` shows the source size while `addr_valid` is high.
- R9: In the writeback word of a batch that is not the last, every field other than the count and the destination size is unchanged. This covers the mode in bits [2:0], the flag in bit [3], the exponent, bits [23:18], and both increment codes.
- R10: A descriptor load whose mode field is 000 is ignored. `addr_valid` and `wb_valid` stay low.
- R11: `xfer_done` outside ST_ACTIVE has no effect. No writeback is produced and no addresses become valid.
- R12: After reset, `addr_valid` and `wb_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_load | input | 1 | Fetched descriptor words are valid this cycle |
| desc_ctrl | input | 32 | Fetched control word |
| desc_src_end | input | 32 | Source end pointer |
| desc_dst_end | input | 32 | Destination end pointer |
| xfer_done | input | 1 | The current transfer has completed |
| addr_valid | output | 1 | Addresses and size are valid (ST_ACTIVE) |
| src_addr | output | 32 | Source address of the current transfer |
| dst_addr | output | 32 | Destination address of the current transfer |
| xfer_size | output | 2 | Transfer size used on both sides |
| count_out | output | 10 | Current remaining count |
| wb_valid | output | 1 | Writeback word is valid (ST_WRITEBACK) |
| wb_word | output | 32 | Updated control word to store back |

## Verification
The hardest situation to reach is the end of a long job. There, a batch boundary, the count reaching zero and the address wrapping below zero must all fall out correctly after hundreds of transfers and reloads. The driver therefore runs whole jobs as a DMA engine would. It reloads each written-back word as the next batch's descriptor and pushes the expected address pairs and writeback words into scoreboard queues. One job has a 1023 count, a word-sized step and a small end pointer, so it crosses the wrap point and ends in the zero-count saturation case.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;

    localparam int CNT_W = 10;
    localparam int EXP_W = 4;
    localparam int CTRL_W = 32;

    localparam logic [2:0] MODE_STOP = 3'b000;
    localparam logic [1:0] INC_NONE = 2'b11;

    typedef struct packed {
        logic [1:0]       dst_inc;
        logic [1:0]       dst_size;
        logic [1:0]       src_inc;
        logic [1:0]       src_size;
        logic [5:0]       spare;
        logic [EXP_W-1:0] batch_exp;
        logic [CNT_W-1:0] remain;
        logic             flag;
        logic [2:0]       mode;
    } ctrl_word_t;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ACTIVE    = 2'd1,
        ST_WRITEBACK = 2'd2
    } ag_state_t;

endpackage

// File: rtl/dma_ag_addr.sv
module dma_ag_addr #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 10
) (
    input  logic [ADDR_W-1:0] end_ptr,
    input  logic [CNT_W-1:0]  remain,
    input  logic [1:0]        inc_code,
    output logic [ADDR_W-1:0] addr
);
    localparam int SHIFT_MAX = 2;

    logic [ADDR_W-1:0] wide_cnt;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        wide_cnt = '0;
        wide_cnt[CNT_W-1:0] = remain;
        offset = '0;
        for (int s = 0; s <= SHIFT_MAX; s++) begin
            if (inc_code == 2'(s)) begin
                offset = wide_cnt << s;
            end
        end
        addr = end_ptr - offset;
    end

endmodule

// File: rtl/dma_ag_count.sv
module dma_ag_count #(
    parameter int CNT_W = 10,
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_remain,
    input  logic [EXP_W-1:0] load_exp,
    input  logic             step,
    output logic [CNT_W-1:0] remain,
    output logic             last_xfer,
    output logic             batch_end
);
    localparam int BCNT_W = (1 << EXP_W) + 1;

    logic [BCNT_W-1:0] batch_cnt;
    logic [EXP_W-1:0]  exp_q;
    logic [BCNT_W-1:0] batch_lim;

    assign batch_lim = (BCNT_W'(1) << exp_q) - BCNT_W'(1);
    assign last_xfer = (remain == '0);
    assign batch_end = (batch_cnt == batch_lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain    <= '0;
            batch_cnt <= '0;
            exp_q     <= '0;
        end else if (load) begin
            remain    <= load_remain;
            batch_cnt <= '0;
            exp_q     <= load_exp;
        end else if (step) begin
            remain    <= last_xfer ? remain : remain - CNT_W'(1);
            batch_cnt <= batch_cnt + BCNT_W'(1);
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && remain != '0) |=> (remain == $past(remain) - CNT_W'(1))); // R5

    AST_COUNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && remain == '0) |=> (remain == '0)); // R7

endmodule

// File: rtl/dma_ag_pack.sv
module dma_ag_pack
    import dma_ag_pkg::*;
#(
    parameter int CNT_W_P = CNT_W
) (
    input  ctrl_word_t          ctrl_q,
    input  logic [CNT_W_P-1:0]  remain,
    input  logic                job_done,
    output ctrl_word_t          wb
);
    always_comb begin
        wb          = ctrl_q;
        wb.remain   = remain;
        wb.dst_size = ctrl_q.src_size;
        if (job_done) begin
            wb.mode = MODE_STOP;
        end
    end
endmodule

// File: rtl/dma_addr_wb.sv
module dma_addr_wb
    import dma_ag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_load,
    input  logic [31:0]       desc_ctrl,
    input  logic [ADDR_W-1:0] desc_src_end,
    input  logic [ADDR_W-1:0] desc_dst_end,
    input  logic              xfer_done,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [1:0]        xfer_size,
    output logic [9:0]        count_out,
    output logic              wb_valid,
    output logic [31:0]       wb_word
);
    ag_state_t  state, state_nx;
    ctrl_word_t ctrl_in, ctrl_q, wb_s;
    logic [ADDR_W-1:0] src_end_q, dst_end_q;
    logic [ADDR_W-1:0] addr_raw [2];
    logic [ADDR_W-1:0] end_q    [2];
    logic [1:0]        inc_q    [2];
    logic load_ok, step, job_done_q;
    logic [CNT_W-1:0] remain;
    logic last_xfer, batch_end;

    assign ctrl_in = ctrl_word_t'(desc_ctrl);
    assign load_ok = (state == ST_IDLE) && desc_load && (ctrl_in.mode != MODE_STOP);
    assign step    = (state == ST_ACTIVE) && xfer_done;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: LOAD, BATCH_END, RETIRE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (load_ok) state_nx = ST_ACTIVE;
            ST_ACTIVE:    if (step && (last_xfer || batch_end)) state_nx = ST_WRITEBACK;
            ST_WRITEBACK: state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Descriptor registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            src_end_q  <= '0;
            dst_end_q  <= '0;
            job_done_q <= 1'b0;
        end else if (load_ok) begin
            ctrl_q     <= ctrl_in;
            src_end_q  <= desc_src_end;
            dst_end_q  <= desc_dst_end;
            job_done_q <= 1'b0;
        end else if (step && last_xfer) begin
            job_done_q <= 1'b1;
        end
    end

    dma_ag_count #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_ok),
        .load_remain(ctrl_in.remain),
        .load_exp   (ctrl_in.batch_exp),
        .step       (step),
        .remain     (remain),
        .last_xfer  (last_xfer),
        .batch_end  (batch_end)
    );

    assign end_q[0] = src_end_q;
    assign end_q[1] = dst_end_q;
    assign inc_q[0] = ctrl_q.src_inc;
    assign inc_q[1] = ctrl_q.dst_inc;

    for (genvar g = 0; g < 2; g++) begin : g_side
        dma_ag_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
            .end_ptr (end_q[g]),
            .remain  (remain),
            .inc_code(inc_q[g]),
            .addr    (addr_raw[g])
        );
    end

    dma_ag_pack u_pack (
        .ctrl_q  (ctrl_q),
        .remain  (remain),
        .job_done(job_done_q),
        .wb      (wb_s)
    );

    // Outputs
    always_comb begin
        addr_valid = 1'b0;
        wb_valid   = 1'b0;
        unique case (state)
            ST_IDLE:      ;
            ST_ACTIVE:    addr_valid = 1'b1;
            ST_WRITEBACK: wb_valid = 1'b1;
            default:      ;
        endcase
        src_addr  = addr_raw[0];
        dst_addr  = addr_raw[1];
        xfer_size = ctrl_q.src_size;
        count_out = remain;
        wb_word   = wb_s;
    end

    AST_WB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid); // R6

    AST_WB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_valid && addr_valid)); // R6

    AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !desc_load && xfer_done) |=> (state == ST_IDLE)); // R11

    AST_STOP_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && desc_load && desc_ctrl[2:0] == MODE_STOP) |=> !addr_valid); // R10

    AST_FINAL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last_xfer) |=> (wb_valid && wb_word[2:0] == MODE_STOP)); // R7

    AST_INC_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && ctrl_q.dst_inc == INC_NONE) |-> (dst_addr == dst_end_q)); // R3

endmodule

// File: tb/dma_addr_wb_test.sv
`timescale 1ns/1ps
module dma_addr_wb_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_load = 1'b0;
    logic [31:0] desc_ctrl = '0;
    logic [31:0] desc_src_end = '0;
    logic [31:0] desc_dst_end = '0;
    logic        xfer_done = 1'b0;
    logic        addr_valid, wb_valid;
    logic [31:0] src_addr, dst_addr, wb_word;
    logic [1:0]  xfer_size;
    logic [9:0]  count_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct packed {
        logic [31:0] s;
        logic [31:0] d;
        logic [1:0]  z;
    } exp_addr_t;

    exp_addr_t   addr_q[$];
    logic [31:0] wb_q[$];

    always #2.5 clk = ~clk;

    dma_addr_wb uut (
        .clk(clk), .rst_n(rst_n), .desc_load(desc_load), .desc_ctrl(desc_ctrl),
        .desc_src_end(desc_src_end), .desc_dst_end(desc_dst_end), .xfer_done(xfer_done),
        .addr_valid(addr_valid), .src_addr(src_addr), .dst_addr(dst_addr),
        .xfer_size(xfer_size), .count_out(count_out), .wb_valid(wb_valid), .wb_word(wb_word)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [2:0] mode, input logic flag, input logic [9:0] cnt,
                                       input logic [3:0] e, input logic [5:0] sp, input logic [1:0] ss,
                                       input logic [1:0] si, input logic [1:0] ds, input logic [1:0] di);
        return {di, ds, si, ss, sp, e, cnt, flag, mode};
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] e, input logic [9:0] c, input logic [1:0] inc);
        if (inc == 2'b11) return e;                 // R3
        return e - ({22'd0, c} << inc);             // R1 R2 R4
    endfunction

    // Monitor: compare design results against scoreboard queues mid-cycle
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (addr_valid && xfer_done) begin
                if (addr_q.size() == 0) begin
                    chk(0, "R5 unexpected transfer", src_addr, 32'h0);
                end else begin
                    exp_addr_t e;
                    e = addr_q.pop_front();
                    chk(src_addr == e.s, "R1 src_addr", src_addr, e.s);
                    chk(dst_addr == e.d, "R2 dst_addr", dst_addr, e.d);
                    chk(xfer_size == e.z, "R8 xfer_size", {30'd0, xfer_size}, {30'd0, e.z});
                end
            end
            if (wb_valid) begin
                chk(!addr_valid, "R6 addr_valid during writeback", {31'd0, addr_valid}, 32'h0);
                if (wb_q.size() == 0) begin
                    chk(0, "R6 unexpected writeback", wb_word, 32'h0);
                end else begin
                    logic [31:0] w;
                    w = wb_q.pop_front();
                    chk(wb_word == w, "R7 R8 R9 wb_word", wb_word, w);
                end
            end
        end
    end

    // Driver: run a whole job, reloading each written-back word
    task automatic run_job(input logic [31:0] s_end, input logic [31:0] d_end, input logic [31:0] ctrl);
        logic [31:0] cur;
        bit fin;
        cur = ctrl;
        fin = 0;
        while (!fin) begin
            int bc;
            bit bend;
            @(posedge clk); #1;
            desc_load = 1'b1; desc_ctrl = cur; desc_src_end = s_end; desc_dst_end = d_end;
            @(posedge clk); #1;
            desc_load = 1'b0;
            bc = 0;
            bend = 0;
            while (!bend) begin
                logic [9:0] c;
                exp_addr_t e;
                c = cur[13:4];
                e.s = exp_addr(s_end, c, cur[27:26]);
                e.d = exp_addr(d_end, c, cur[31:30]);
                e.z = cur[25:24];
                addr_q.push_back(e);
                xfer_done = 1'b1;
                @(posedge clk); #1;
                xfer_done = 1'b0;
                bc++;
                fin = (c == 10'd0);
                cur[13:4] = fin ? 10'd0 : c - 10'd1;          // R5 R7
                bend = fin || (bc == (1 << cur[17:14]));       // R6
                if (bend) begin
                    cur[29:28] = cur[25:24];                   // R8
                    if (fin) cur[2:0] = 3'b000;                // R7
                    wb_q.push_back(cur);
                end
            end
        end
        @(posedge clk); #1;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R12: reset state
        chk(!addr_valid, "R12 addr_valid after reset", {31'd0, addr_valid}, 32'h0);
        chk(!wb_valid, "R12 wb_valid after reset", {31'd0, wb_valid}, 32'h0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R10: stop-mode descriptor ignored
        desc_load = 1'b1; desc_ctrl = mk(3'b000, 0, 10'd5, 4'd2, 6'd0, 2'd1, 2'd0, 2'd1, 2'd0);
        @(posedge clk); #1;
        desc_load = 1'b0;
        @(negedge clk);
        chk(!addr_valid, "R10 addr_valid after stop load", {31'd0, addr_valid}, 32'h0);
        chk(!wb_valid, "R10 wb_valid after stop load", {31'd0, wb_valid}, 32'h0);

        // R11: done strobe while idle ignored
        @(posedge clk); #1;
        xfer_done = 1'b1;
        @(posedge clk); #1;
        xfer_done = 1'b0;
        @(negedge clk);
        chk(!wb_valid, "R11 wb_valid after idle done", {31'd0, wb_valid}, 32'h0);
        chk(!addr_valid, "R11 addr_valid after idle done", {31'd0, addr_valid}, 32'h0);

        // Byte steps, batches of 2, unequal sizes
        run_job(32'h1000_0040, 32'h2000_0080, mk(3'b001, 1, 10'd3, 4'd1, 6'h2A, 2'd1, 2'd0, 2'd2, 2'd0));
        // Halfword / word steps, one batch covers whole job, ping-pong mode
        run_job(32'h3000_0100, 32'h4000_0200, mk(3'b011, 0, 10'd2, 4'd10, 6'h15, 2'd2, 2'd1, 2'd2, 2'd2));
        // R3 R4: wrap below zero on source, fixed destination, batches of 1
        run_job(32'h0000_0001, 32'h5555_0000, mk(3'b010, 1, 10'd2, 4'd0, 6'h3F, 2'd0, 2'd0, 2'd3, 2'd3));
        // Long job: word step wraps, fixed source, batches of 4
        run_job(32'h0000_0100, 32'h0000_0800, mk(3'b110, 0, 10'd1023, 4'd2, 6'h01, 2'd2, 2'd3, 2'd0, 2'd2));

        repeat (2) @(posedge clk);
        chk(addr_q.size() == 0, "R5 pending transfers", addr_q.size(), 32'h0);
        chk(wb_q.size() == 0, "R6 pending writebacks", wb_q.size(), 32'h0);
        @(negedge clk);
        chk(!addr_valid && !wb_valid, "R7 idle after final writeback", {30'd0, addr_valid, wb_valid}, 32'h0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule